// File: doc/BRIEF.md
# AES Stream Length Sequencer

This block is the control sequencer that sits beside an AES datapath. It decides when the engine may ask for another 16-byte input block and when a stream is over. It holds three pieces of context: a 64-bit crypto length, a 32-bit authentication length and a mode control word. The host writes each of them through a small write port. Each block that the engine consumes lowers the remaining length. Authentication bytes are used up before crypto bytes, and each block takes at most 16 bytes of what is left.

A length of zero does not mean the same thing in every mode. In the basic modes (ECB, CBC, CTR), a zero length means the stream runs without end until a new control word arrives. In the authenticated modes (CBC-MAC, GCM, CCM), a zero length means no block is requested at all. The lengths stay in place when a new control word is written. Once a stream is used up, a write to a length register starts requests again.

The block also gates host reads of the shared tag/IV output word. While processing is under way the tag reads as zero. A mode that produces no tag shows the IV in the tag slot. In a tag-producing mode, reading the IV first overwrites the shared slot, so a later tag read returns the IV.

Top module: `aes_stream_seq`

## Requirements
- R1: After reset `data_req` and `eos` are 0, `ctx_req` is 1, `is_ecb` is 1, `is_auth` is 0, and a tag read returns the IV word.
- R2: A write with `wr_en` high is decoded by `wr_addr`: 0 loads the control word and starts a new context, 1 loads crypto length bits [31:0], 2 loads crypto length bits [63:32], 3 loads the authentication length. Addresses 4 to 7 change nothing.
- R3: `is_ecb` is 1 exactly when bits [28:5] of the last control word are all 0. `is_auth` is 1 exactly when bit 15 (CBC-MAC), bit 16 (GCM) or bit 18 (CCM) of that word is set. Any other word selects a basic mode.
- R4: A `blk_take` pulse is accepted only while `data_req` is high and `wr_en` is low. An accepted pulse lowers the authentication length by min(16, remaining) while that length is nonzero, and otherwise lowers the crypto length by min(16, remaining).
- R5: When an accepted block brings both lengths to 0, `eos` is high for exactly the next cycle and `data_req` falls at the same time. `ctx_req` is always the inverse of `data_req`.
- R6: In a basic mode, a context or length write that leaves both lengths at 0 keeps `data_req` high through any number of blocks. This lasts until a write that leaves a nonzero length, or a control word for an authenticated mode.
- R7: In an authenticated mode, `data_req` is 0 whenever both lengths are 0.
- R8: A control word write keeps the current length values, and requests resume whenever those values are nonzero.
- R9: After a stream is used up, writing a nonzero length raises `data_req` again in the next cycle, without a new control word.
- R10: While `data_req` is high, a tag read (`rd_sel`=0) returns 0.
- R11: When not processing, in a mode without a tag (any basic mode), a tag read returns the IV word.
- R12: When not processing, in an authenticated mode, a tag read returns the tag word until an IV read (`rd_en` with `rd_sel`=1) is made. After that it returns the IV word until the next control word write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Host register write strobe |
| wr_addr | input | 3 | Write target select |
| wr_data | input | 32 | Write data |
| blk_take | input | 1 | Engine consumed one requested block |
| rd_en | input | 1 | Host read strobe for the output word |
| rd_sel | input | 1 | 0 selects tag slot, 1 selects IV |
| tag_word | input | 32 | Tag value from the datapath |
| iv_word | input | 32 | IV value from the datapath |
| data_req | output | 1 | Engine may request another block |
| ctx_req | output | 1 | Stream finished or idle; a new context is wanted |
| eos | output | 1 | One-cycle end-of-stream pulse |
| is_ecb | output | 1 | Current mode decodes as ECB |
| is_auth | output | 1 | Current mode is an authenticated mode |
| rd_data | output | 32 | Gated tag/IV read data |

## Verification
The bench first goes after the zero-length split. If a design treats a zero length in ECB mode as "stop", `data_req` drops at once. If it treats a zero in GCM or CCM as "stream forever", it requests blocks that never end. Other runs check the consumption order: the authentication length is rewritten in the middle of a stream, so a design that takes crypto bytes first finishes one block early. A pulse that arrives together with a write, and a write to an unused address, must leave the block count unchanged. The readout order is exercised by reading the IV before the tag. A design that does not invalidate the tag would return the tag there instead of the IV, and one that forgets to clear the flag on a new context keeps returning the IV.

// File: rtl/aes_sls_pkg.sv
package aes_sls_pkg;

   // write targets on the host port
   localparam logic [2:0] WA_CTRL    = 3'd0;
   localparam logic [2:0] WA_CLEN_LO = 3'd1;
   localparam logic [2:0] WA_CLEN_HI = 3'd2;
   localparam logic [2:0] WA_ALEN    = 3'd3;

   typedef enum logic {
      RSEL_TAG = 1'b0,
      RSEL_IV  = 1'b1
   } rsel_e;

   typedef struct packed {
      logic ecb;
      logic auth;
   } mode_cls_t;

endpackage

// File: rtl/aes_sls_len_ctr.sv
module aes_sls_len_ctr #(
   parameter int CNT_W  = 64,
   parameter int WORD_W = 32,
   parameter int STEP   = 16,
   parameter int IDX_W  = ((CNT_W / WORD_W) > 1) ? $clog2(CNT_W / WORD_W) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ld_en,
   input  logic [IDX_W-1:0]  ld_idx,
   input  logic [WORD_W-1:0] ld_data,
   input  logic              dec_en,
   output logic [CNT_W-1:0]  cnt_q,
   output logic [CNT_W-1:0]  cnt_nxt,
   output logic              zero_q,
   output logic              zero_nxt
);

   localparam int NW = CNT_W / WORD_W;
   localparam logic [CNT_W-1:0] STEP_V = CNT_W'(STEP);

   if (CNT_W % WORD_W != 0) begin : g_bad_w
      $error("CNT_W must be a multiple of WORD_W");
   end
   if (STEP < 1) begin : g_bad_step
      $error("STEP must be positive");
   end

   logic [CNT_W-1:0] dec_val;
   assign dec_val = (cnt_q < STEP_V) ? '0 : (cnt_q - STEP_V);

   if (NW == 1) begin : g_single
      logic unused_idx;
      assign unused_idx = ^ld_idx;
      always_comb begin
         cnt_nxt = cnt_q;
         if (ld_en)       cnt_nxt = ld_data;
         else if (dec_en) cnt_nxt = dec_val;
      end
   end else begin : g_multi
      always_comb begin
         cnt_nxt = cnt_q;
         if (ld_en) begin
            for (int i = 0; i < NW; i++) begin
               if (ld_idx == IDX_W'(i)) cnt_nxt[i*WORD_W +: WORD_W] = ld_data;
            end
         end else if (dec_en) begin
            cnt_nxt = dec_val;
         end
      end
   end

   assign zero_nxt = (cnt_nxt == '0);
   assign zero_q   = (cnt_q == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt_q <= '0;
      else        cnt_q <= cnt_nxt;
   end

   // R4: a decrement never raises the count and removes at most one block
   a_r4_step_bound: assert property (@(posedge clk) disable iff (!rst_n)
      (dec_en && !ld_en) |=> ((cnt_q <= $past(cnt_q)) && (($past(cnt_q) - cnt_q) <= STEP_V)));

   // R4: a decrement of a nonzero count always makes progress
   a_r4_progress: assert property (@(posedge clk) disable iff (!rst_n)
      (dec_en && !ld_en && !zero_q) |=> (cnt_q != $past(cnt_q)));

endmodule

// File: rtl/aes_sls_mode_dec.sv
module aes_sls_mode_dec
   import aes_sls_pkg::*;
#(
   parameter int CTRL_W    = 32,
   parameter int ECB_LO    = 5,
   parameter int ECB_HI    = 28,
   parameter int CBCMAC_B  = 15,
   parameter int GCM_B     = 16,
   parameter int CCM_B     = 18
) (
   input  logic [CTRL_W-1:0] ctrl,
   output mode_cls_t         cls
);

   if (ECB_HI >= CTRL_W || ECB_LO > ECB_HI || ECB_LO < 1 || ECB_HI + 1 >= CTRL_W) begin : g_bad_rng
      $error("mode field range does not fit the control word");
   end
   if (CBCMAC_B > ECB_HI || GCM_B > ECB_HI || CCM_B > ECB_HI ||
       CBCMAC_B < ECB_LO || GCM_B < ECB_LO || CCM_B < ECB_LO) begin : g_bad_bits
      $error("authenticated mode bits must lie in the mode field");
   end

   logic unused_ctrl;
   assign unused_ctrl = ^{ctrl[ECB_LO-1:0], ctrl[CTRL_W-1:ECB_HI+1]};

   assign cls.ecb  = (ctrl[ECB_HI:ECB_LO] == '0);
   assign cls.auth = ctrl[CBCMAC_B] | ctrl[GCM_B] | ctrl[CCM_B];

endmodule

// File: rtl/aes_sls_readout.sv
module aes_sls_readout
   import aes_sls_pkg::*;
#(
   parameter int DW = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          busy,
   input  logic          has_tag,
   input  logic          ctx_load,
   input  logic          rd_en,
   input  rsel_e         rd_sel,
   input  logic [DW-1:0] tag_word,
   input  logic [DW-1:0] iv_word,
   output logic [DW-1:0] rd_data
);

   if (DW < 1) begin : g_bad_dw
      $error("DW must be positive");
   end

   // set once the IV has overwritten the shared output slot
   logic iv_taken_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                       iv_taken_q <= 1'b0;
      else if (ctx_load)                                iv_taken_q <= 1'b0;
      else if (rd_en && rd_sel == RSEL_IV && !busy)     iv_taken_q <= 1'b1;
   end

   always_comb begin
      if (rd_sel == RSEL_IV)        rd_data = iv_word;
      else if (busy)                rd_data = '0;
      else if (!has_tag)            rd_data = iv_word;
      else if (iv_taken_q)          rd_data = iv_word;
      else                          rd_data = tag_word;
   end

   // R10: the tag slot is blank while work is pending
   a_r10_tag_blank: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && rd_sel == RSEL_TAG) |-> (rd_data == '0));

   // R12: a new context always re-exposes the tag
   a_r12_ctx_clears: assert property (@(posedge clk) disable iff (!rst_n)
      ctx_load |=> !iv_taken_q);

endmodule

// File: rtl/aes_stream_seq.sv
module aes_stream_seq
   import aes_sls_pkg::*;
#(
   parameter int DATA_W    = 32,
   parameter int CRYPTO_W  = 64,
   parameter int AUTH_W    = 32,
   parameter int BLK_BYTES = 16,
   parameter int ADDR_W    = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              blk_take,
   input  logic              rd_en,
   input  logic              rd_sel,
   input  logic [DATA_W-1:0] tag_word,
   input  logic [DATA_W-1:0] iv_word,
   output logic              data_req,
   output logic              ctx_req,
   output logic              eos,
   output logic              is_ecb,
   output logic              is_auth,
   output logic [DATA_W-1:0] rd_data
);

   localparam int CWORDS = CRYPTO_W / DATA_W;
   localparam int CIDX_W = (CWORDS > 1) ? $clog2(CWORDS) : 1;

   if (AUTH_W != DATA_W) begin : g_bad_auth
      $error("AUTH_W must equal DATA_W");
   end
   if (ADDR_W < 2) begin : g_bad_addr
      $error("ADDR_W must be at least 2");
   end
   if (CWORDS != 2) begin : g_bad_crypto
      $error("crypto length must span exactly two data words");
   end

   // ---------------- write decode
   logic wr_ctl, wr_clo, wr_chi, wr_aut, any_wr;
   assign wr_ctl = wr_en && (wr_addr == ADDR_W'(WA_CTRL));
   assign wr_clo = wr_en && (wr_addr == ADDR_W'(WA_CLEN_LO));
   assign wr_chi = wr_en && (wr_addr == ADDR_W'(WA_CLEN_HI));
   assign wr_aut = wr_en && (wr_addr == ADDR_W'(WA_ALEN));
   assign any_wr = wr_ctl | wr_clo | wr_chi | wr_aut;

   // ---------------- block acceptance
   logic take, auth_dec, crypt_dec;
   logic a_zero_q, a_zero_nxt, c_zero_q, c_zero_nxt;
   logic [AUTH_W-1:0]   a_cnt_q, a_cnt_nxt;
   logic [CRYPTO_W-1:0] c_cnt_q, c_cnt_nxt;

   assign take      = blk_take && data_req && !wr_en;
   assign auth_dec  = take && !a_zero_q;
   assign crypt_dec = take && a_zero_q && !c_zero_q;

   aes_sls_len_ctr #(
      .CNT_W (CRYPTO_W),
      .WORD_W(DATA_W),
      .STEP  (BLK_BYTES),
      .IDX_W (CIDX_W)
   ) u_crypt_len (
      .clk     (clk),
      .rst_n   (rst_n),
      .ld_en   (wr_clo | wr_chi),
      .ld_idx  (CIDX_W'(wr_chi)),
      .ld_data (wr_data),
      .dec_en  (crypt_dec),
      .cnt_q   (c_cnt_q),
      .cnt_nxt (c_cnt_nxt),
      .zero_q  (c_zero_q),
      .zero_nxt(c_zero_nxt)
   );

   aes_sls_len_ctr #(
      .CNT_W (AUTH_W),
      .WORD_W(DATA_W),
      .STEP  (BLK_BYTES),
      .IDX_W (1)
   ) u_auth_len (
      .clk     (clk),
      .rst_n   (rst_n),
      .ld_en   (wr_aut),
      .ld_idx  (1'b0),
      .ld_data (wr_data),
      .dec_en  (auth_dec),
      .cnt_q   (a_cnt_q),
      .cnt_nxt (a_cnt_nxt),
      .zero_q  (a_zero_q),
      .zero_nxt(a_zero_nxt)
   );

   logic unused_cnt;
   assign unused_cnt = ^{a_cnt_nxt, c_cnt_nxt};

   // ---------------- mode context
   mode_cls_t dec_cls, cls_q, cls_nxt;

   aes_sls_mode_dec #(.CTRL_W(DATA_W)) u_mode_dec (
      .ctrl(wr_data),
      .cls (dec_cls)
   );

   assign cls_nxt = wr_ctl ? dec_cls : cls_q;

   logic armed_q, endless_q, eos_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cls_q     <= '{ecb: 1'b1, auth: 1'b0};
         armed_q   <= 1'b0;
         endless_q <= 1'b0;
         eos_q     <= 1'b0;
      end else begin
         cls_q <= cls_nxt;
         if (wr_ctl) armed_q <= 1'b1;
         // a zero length in a basic mode streams until the next context
         if (any_wr) endless_q <= !cls_nxt.auth && a_zero_nxt && c_zero_nxt;
         eos_q <= take && !endless_q && a_zero_nxt && c_zero_nxt;
      end
   end

   assign data_req = armed_q && (endless_q || !a_zero_q || !c_zero_q);
   assign ctx_req  = !data_req;
   assign eos      = eos_q;
   assign is_ecb   = cls_q.ecb;
   assign is_auth  = cls_q.auth;

   // ---------------- shared tag / IV output
   aes_sls_readout #(.DW(DATA_W)) u_readout (
      .clk     (clk),
      .rst_n   (rst_n),
      .busy    (data_req),
      .has_tag (cls_q.auth),
      .ctx_load(wr_ctl),
      .rd_en   (rd_en),
      .rd_sel  (rsel_e'(rd_sel)),
      .tag_word(tag_word),
      .iv_word (iv_word),
      .rd_data (rd_data)
   );

   // R7: authenticated modes never stream on an empty length
   a_r7_auth_stop: assert property (@(posedge clk) disable iff (!rst_n)
      (cls_q.auth && a_zero_q && c_zero_q) |-> !data_req);

   // R6: an endless basic stream survives block consumption
   a_r6_endless_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (data_req && endless_q && !wr_en) |=> data_req);

   // R4: authentication bytes are used before crypto bytes
   a_r4_auth_first: assert property (@(posedge clk) disable iff (!rst_n)
      (take && !a_zero_q) |=> $stable(c_cnt_q));

   // R5: end of stream coincides with a context request
   a_r5_eos_ctx: assert property (@(posedge clk) disable iff (!rst_n)
      eos |-> ctx_req);

   // R5: end of stream is a single-cycle pulse
   a_r5_eos_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      eos |=> !eos);

   // R4: a block offered while idle leaves both lengths untouched
   a_r4_idle_take: assert property (@(posedge clk) disable iff (!rst_n)
      (blk_take && !data_req && !wr_en) |=> ($stable(c_cnt_q) && $stable(a_cnt_q)));

endmodule

// File: tb/aes_stream_seq_tb.sv
`timescale 1ns/1ps
module aes_stream_seq_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [2:0]  wr_addr = '0;
   logic [31:0] wr_data = '0;
   logic        blk_take = 1'b0;
   logic        rd_en = 1'b0;
   logic        rd_sel = 1'b0;
   logic [31:0] tag_word = 32'hA5A5_0001;
   logic [31:0] iv_word  = 32'h1F1F_0002;
   logic        data_req, ctx_req, eos, is_ecb, is_auth;
   logic [31:0] rd_data;

   int checks = 0;
   int fails  = 0;
   int cycles = 0;
   bit done   = 0;

   always #2 clk = ~clk;

   aes_stream_seq dut_i (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .blk_take(blk_take), .rd_en(rd_en), .rd_sel(rd_sel), .tag_word(tag_word),
      .iv_word(iv_word), .data_req(data_req), .ctx_req(ctx_req), .eos(eos),
      .is_ecb(is_ecb), .is_auth(is_auth), .rd_data(rd_data)
   );

   // ---------------- behavioural reference model
   bit              m_armed = 0, m_auth = 0, m_ecb = 1, m_endless = 0, m_ivt = 0, m_eos = 0;
   longint unsigned m_clen = 0;
   longint unsigned m_alen = 0;

   function automatic bit m_req();
      return m_armed && (m_endless || m_clen != 0 || m_alen != 0);
   endfunction

   function automatic logic [31:0] m_rd(input logic sel);
      if (sel) return iv_word;
      if (m_req()) return 32'h0;
      if (!m_auth || m_ivt) return iv_word;
      return tag_word;
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_armed = 0; m_auth = 0; m_ecb = 1; m_endless = 0; m_ivt = 0; m_eos = 0;
         m_clen = 0; m_alen = 0;
      end else begin
         bit req0, tk;
         req0 = m_req();
         tk = blk_take && req0 && !wr_en;
         if (rd_en && rd_sel && !req0) m_ivt = 1;
         if (wr_en) begin
            case (wr_addr)
               3'd0: begin
                  m_auth = wr_data[15] | wr_data[16] | wr_data[18];
                  m_ecb = (wr_data[28:5] == 24'h0);
                  m_armed = 1; m_ivt = 0;
               end
               3'd1: m_clen = {m_clen[63:32], wr_data};
               3'd2: m_clen = {wr_data, m_clen[31:0]};
               3'd3: m_alen = longint'(wr_data);
               default: ;
            endcase
            if (wr_addr <= 3'd3) m_endless = !m_auth && m_clen == 0 && m_alen == 0;
         end
         m_eos = 0;
         if (tk) begin
            if (m_alen != 0)      m_alen = (m_alen < 16) ? 0 : m_alen - 16;
            else if (m_clen != 0) m_clen = (m_clen < 16) ? 0 : m_clen - 16;
            m_eos = !m_endless && m_alen == 0 && m_clen == 0;
         end
      end
   end

   // per-cycle comparison, away from the active edge
   always @(negedge clk) begin
      if (rst_n && !done) begin
         checks++;
         if (data_req !== m_req() || ctx_req !== !m_req()) begin
            fails++;
            $display("FAIL R5 req/ctx actual=%b/%b expected=%b/%b", data_req, ctx_req, m_req(), !m_req());
         end
         if (eos !== m_eos) begin
            fails++;
            $display("FAIL R5 eos actual=%b expected=%b", eos, m_eos);
         end
         if (is_ecb !== m_ecb || is_auth !== m_auth) begin
            fails++;
            $display("FAIL R3 class actual=%b%b expected=%b%b", is_ecb, is_auth, m_ecb, m_auth);
         end
         if (rd_data !== m_rd(rd_sel)) begin
            fails++;
            $display("FAIL R12 rd_data actual=%h expected=%h", rd_data, m_rd(rd_sel));
         end
      end
   end

   // ---------------- helpers
   task automatic dchk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic op(input logic we, input logic [2:0] a, input logic [31:0] d,
                     input logic tk, input logic re, input logic rs);
      @(negedge clk); #1;
      wr_en = we; wr_addr = a; wr_data = d; blk_take = tk; rd_en = re; rd_sel = rs;
      @(posedge clk); #1;
      wr_en = 0; wr_addr = '0; wr_data = '0; blk_take = 0; rd_en = 0; rd_sel = 0;
   endtask

   task automatic wr(input logic [2:0] a, input logic [31:0] d);
      op(1'b1, a, d, 1'b0, 1'b0, 1'b0);
   endtask

   task automatic take1();
      op(1'b0, 3'd0, 32'h0, 1'b1, 1'b0, 1'b0);
   endtask

   task automatic settle();
      @(negedge clk);
   endtask

   task automatic peek(input logic sel, output logic [31:0] v);
      @(negedge clk); #1;
      rd_sel = sel;
      @(negedge clk);
      v = rd_data;
   endtask

   task automatic finish_run();
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   endtask

   // watchdog
   always @(posedge clk) begin
      cycles++;
      if (cycles > 20000 && !done) begin
         checks++; fails++;
         $display("FAIL watchdog actual=%0d expected<=%0d", cycles, 20000);
         finish_run();
      end
   end

   // ---------------- directed scenarios
   initial begin
      logic [31:0] v;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;

      // R1 reset state
      settle();
      dchk("R1 data_req", {31'h0, data_req}, 32'h0);
      dchk("R1 ctx_req", {31'h0, ctx_req}, 32'h1);
      dchk("R1 eos", {31'h0, eos}, 32'h0);
      dchk("R1 is_ecb", {31'h0, is_ecb}, 32'h1);
      peek(1'b0, v);
      dchk("R1 R11 tag slot shows IV", v, 32'h1F1F_0002);

      // R6 ECB with zero length streams indefinitely
      wr(3'd0, 32'h0);
      settle();
      dchk("R6 endless req", {31'h0, data_req}, 32'h1);
      dchk("R3 ecb", {31'h0, is_ecb}, 32'h1);
      repeat (4) take1();
      settle();
      dchk("R6 still requesting", {31'h0, data_req}, 32'h1);
      peek(1'b0, v);
      dchk("R10 tag blank while busy", v, 32'h0);

      // R8 lengths kept across a control write; R2/R4 ignored cases
      wr(3'd1, 32'd40);
      wr(3'd0, 32'h0000_0020);
      settle();
      dchk("R3 cbc not ecb", {31'h0, is_ecb}, 32'h0);
      dchk("R8 reuse length", {31'h0, data_req}, 32'h1);
      take1();                                   // 40 -> 24
      op(1'b1, 3'd5, 32'd1000, 1'b1, 1'b0, 1'b0); // ignored write and ignored take
      take1();                                   // 24 -> 8
      settle();
      dchk("R2 R4 ignored take and address", {31'h0, data_req}, 32'h1);
      dchk("R4 no early eos", {31'h0, eos}, 32'h0);
      take1();                                   // 8 -> 0
      settle();
      dchk("R5 eos pulse", {31'h0, eos}, 32'h1);
      dchk("R5 req drops", {31'h0, data_req}, 32'h0);
      dchk("R5 ctx_req", {31'h0, ctx_req}, 32'h1);
      settle();
      dchk("R5 eos one cycle", {31'h0, eos}, 32'h0);
      peek(1'b0, v);
      dchk("R11 basic mode tag slot", v, 32'h1F1F_0002);

      // R4 block offered while idle
      take1();
      settle();
      dchk("R4 idle take ignored", {31'h0, data_req | eos}, 32'h0);

      // R9 re-arm by length write
      wr(3'd1, 32'd16);
      settle();
      dchk("R9 rearm", {31'h0, data_req}, 32'h1);
      take1();
      settle();
      dchk("R9 single block eos", {31'h0, eos}, 32'h1);

      // R7 GCM with empty lengths does not stream
      wr(3'd0, 32'h0001_0000);
      settle();
      dchk("R7 auth zero no req", {31'h0, data_req}, 32'h0);
      dchk("R3 gcm auth", {31'h0, is_auth}, 32'h1);

      // R4 auth consumed first: auth 20, crypto 33, rewrite auth mid-stream
      wr(3'd3, 32'd20);
      wr(3'd1, 32'd33);
      take1();                                   // auth 20 -> 4
      peek(1'b0, v);
      dchk("R10 tag zero mid-stream", v, 32'h0);
      wr(3'd3, 32'd0);                           // crypto still 33
      take1(); take1();
      settle();
      dchk("R4 auth first ordering", {31'h0, data_req}, 32'h1);
      take1();
      settle();
      dchk("R4 R5 eos after crypto", {31'h0, eos}, 32'h1);

      // R12 readout ordering
      peek(1'b0, v);
      dchk("R12 tag before IV read", v, 32'hA5A5_0001);
      peek(1'b1, v);
      dchk("R12 IV slot", v, 32'h1F1F_0002);
      op(1'b0, 3'd0, 32'h0, 1'b0, 1'b1, 1'b1);   // IV read
      peek(1'b0, v);
      dchk("R12 tag after IV read", v, 32'h1F1F_0002);
      tag_word = 32'h0BAD_CAFE;
      wr(3'd0, 32'h0001_0000);
      peek(1'b0, v);
      dchk("R12 new context re-exposes tag", v, 32'h0BAD_CAFE);

      // 64-bit length, CCM, R7 stop on zero
      wr(3'd2, 32'd1);
      take1();
      wr(3'd0, 32'h0004_0000);
      settle();
      dchk("R8 CCM keeps 64-bit length", {31'h0, data_req}, 32'h1);
      wr(3'd2, 32'd0);
      wr(3'd1, 32'd0);
      settle();
      dchk("R7 CCM zero stops", {31'h0, data_req}, 32'h0);
      wr(3'd1, 32'd8);
      take1();
      settle();
      dchk("R4 partial block ends stream", {31'h0, eos}, 32'h1);

      // R3 field boundaries
      wr(3'd0, 32'h2000_001F);
      settle();
      dchk("R3 bits outside field keep ECB", {31'h0, is_ecb}, 32'h1);
      dchk("R6 ECB zero streams", {31'h0, data_req}, 32'h1);
      wr(3'd0, 32'h1000_0000);
      settle();
      dchk("R3 bit 28 not ECB", {31'h0, is_ecb}, 32'h0);
      dchk("R6 basic zero streams", {31'h0, data_req}, 32'h1);
      wr(3'd0, 32'h0000_8000);
      settle();
      dchk("R3 CBC-MAC auth", {31'h0, is_auth}, 32'h1);
      dchk("R7 CBC-MAC zero stops", {31'h0, data_req}, 32'h0);

      repeat (3) settle();
      finish_run();
   end

endmodule